// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers that a processor core sees, with the physical storage behind each register number chosen by the current operating mode. A 5-bit mode input selects the visible bank. The low eight registers are one shared set. The fast-interrupt mode swaps in its own copies of registers 8 through 14. Every other exception mode swaps in only its own stack pointer and link register (13 and 14). User and system mode look at the same storage.

Two combinational read ports and one clocked write port each take a 4-bit register number. Register 15 is the program counter, which lives outside the block. Reads of it return the `pc_i` input, and writes to it are dropped. A separate port reads and writes the saved status word that belongs to the current exception mode. In the unprivileged bank that port reads zero and ignores writes.

Top module: `bank_rf`

## Requirements
- R1: Both read ports return, with no clock delay, the content of the physical register that the current `mode_i` maps the requested register number to.
- R2: Registers 0 to 7 are one shared set: a value written in any mode is read back in every mode.
- R3: Mode 0b10001 (fast interrupt) has private copies of registers 8 to 12. All other modes share the user copies of them.
- R4: Each of the modes 0b10001, 0b10010 (interrupt), 0b10011 (supervisor), 0b10111 (abort) and 0b11011 (undefined) has its own registers 13 and 14. Mode 0b10000 (user) and 0b11111 (system) share one pair.
- R5: Reading register 15 on either port returns `pc_i`. Writing register 15 changes no stored register.
- R6: Each of the five exception modes in R4 owns one saved status word. `sr_rd_data` shows the current mode's word, and `sr_wr_en` updates it at the clock edge.
- R7: In user and system mode `sr_rd_data` is zero and `sr_wr_en` changes no saved status word.
- R8: Writes take effect at the rising clock edge. A read of the register being written in the same cycle returns the old value.
- R9: A mode encoding outside the seven listed selects the user bank, so its saved status read is zero and its saved status write is dropped.
- R10: While `rst_n` is low at a rising edge, every stored register and saved status word is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 5 | Current operating mode encoding |
| rd_a_idx | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register number to write |
| wr_data | input | 32 | Register write data |
| pc_i | input | 32 | Program counter value returned for register 15 |
| sr_wr_en | input | 1 | Saved status write enable |
| sr_wr_data | input | 32 | Saved status write data |
| sr_rd_data | output | 32 | Saved status word of the current mode |

## Verification
A register write and a read of the same register number can fall in the same cycle, on either port and in the same or a different mode. The random stream reuses a small set of register numbers and modes so that such collisions occur often. Directed steps also force them, including a write to register 15 alongside reads of it. Each read is judged against a bench model whose state is updated only after the comparison for that cycle. A correct read therefore returns the value held before the edge, or `pc_i` for register 15.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;

   localparam int MODE_W   = 5;
   localparam int ARCH_W   = 4;
   localparam int ARCH_N   = 16;
   localparam int SHARED_N = 8;     // registers 0..7 never banked
   localparam int PRIV_LO  = 13;    // first register banked in every exception mode
   localparam int PC_IDX   = 15;
   localparam int FIQ_BASE = 15;    // physical slots 0..14 hold shared + user copies
   localparam int FIQ_N    = PC_IDX - SHARED_N;              // 7 private fast-irq slots
   localparam int PRIV_BASE = FIQ_BASE + FIQ_N;              // 22
   localparam int PRIV_PER  = PC_IDX - PRIV_LO;              // 2
   localparam int PRIV_MODES = 4;
   localparam int PHYS_N   = PRIV_BASE + PRIV_PER * PRIV_MODES; // 30
   localparam int PHYS_W   = $clog2(PHYS_N);
   localparam int SLOT_N   = 5;
   localparam int SLOT_W   = $clog2(SLOT_N);

   localparam logic [MODE_W-1:0] MD_USER = 5'b10000;
   localparam logic [MODE_W-1:0] MD_FAST = 5'b10001;
   localparam logic [MODE_W-1:0] MD_INTR = 5'b10010;
   localparam logic [MODE_W-1:0] MD_SUPV = 5'b10011;
   localparam logic [MODE_W-1:0] MD_ABRT = 5'b10111;
   localparam logic [MODE_W-1:0] MD_UNDF = 5'b11011;
   localparam logic [MODE_W-1:0] MD_SYST = 5'b11111;

   typedef enum logic [2:0] {
      BK_USR = 3'd0,
      BK_FIQ = 3'd1,
      BK_IRQ = 3'd2,
      BK_SVC = 3'd3,
      BK_ABT = 3'd4,
      BK_UND = 3'd5
   } bank_e;

   function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
      bank_e b;
      case (m)
         MD_FAST: b = BK_FIQ;
         MD_INTR: b = BK_IRQ;
         MD_SUPV: b = BK_SVC;
         MD_ABRT: b = BK_ABT;
         MD_UNDF: b = BK_UND;
         default: b = BK_USR;   // user, system and unknown encodings
      endcase
      return b;
   endfunction

   // physical slot for an architectural number; register 15 is never stored
   function automatic logic [PHYS_W-1:0] phys_of(input bank_e b, input logic [ARCH_W-1:0] a);
      int r;
      int ai;
      ai = int'(a);
      if (ai < SHARED_N || b == BK_USR) begin
         r = ai;
      end else if (b == BK_FIQ) begin
         r = FIQ_BASE + (ai - SHARED_N);
      end else if (ai < PRIV_LO) begin
         r = ai;
      end else begin
         r = PRIV_BASE + PRIV_PER * (int'(b) - int'(BK_IRQ)) + (ai - PRIV_LO);
      end
      if (r >= PHYS_N) r = 0;
      return PHYS_W'(r);
   endfunction

endpackage

// File: rtl/bank_rf_decode.sv
module bank_rf_decode
   import bank_rf_pkg::*;
#(
   parameter int NPORT = 3
) (
   input  logic [MODE_W-1:0]             mode_i,
   input  logic [NPORT-1:0][ARCH_W-1:0]  arch_idx,
   output logic [NPORT-1:0][PHYS_W-1:0]  phys_idx,
   output logic                          has_sr,
   output logic [SLOT_W-1:0]             sr_slot
);

   bank_e bank;

   always_comb begin
      bank    = mode_to_bank(mode_i);
      has_sr  = (bank != BK_USR);
      sr_slot = has_sr ? SLOT_W'(int'(bank) - 1) : '0;
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      always_comb phys_idx[p] = phys_of(bank, arch_idx[p]);
   end

endmodule

// File: rtl/bank_rf_store.sv
module bank_rf_store #(
   parameter int               DATA_W  = 32,
   parameter int               DEPTH   = 30,
   parameter int               NRD     = 2,
   parameter logic [DATA_W-1:0] RST_VAL = '0,
   localparam int              IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [IDX_W-1:0]              widx,
   input  logic [DATA_W-1:0]             wdata,
   input  logic [NRD-1:0][IDX_W-1:0]     ridx,
   output logic [NRD-1:0][DATA_W-1:0]    rdata
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("bank_rf_store: DEPTH must be at least 1");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("bank_rf_store: NRD must be at least 1");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mem[e] <= RST_VAL;
         end else if (we && widx == IDX_W'(e)) begin
            mem[e] <= wdata;
         end
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      always_comb begin
         if (int'(ridx[p]) < DEPTH) rdata[p] = mem[ridx[p]];
         else                       rdata[p] = '0;
      end
   end

endmodule

// File: rtl/bank_rf.sv
module bank_rf
   import bank_rf_pkg::*;
#(
   parameter int                DATA_W  = 32,
   parameter int                SR_W    = 32,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        mode_i,
   input  logic [3:0]        rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [3:0]        rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] pc_i,
   input  logic              sr_wr_en,
   input  logic [SR_W-1:0]   sr_wr_data,
   output logic [SR_W-1:0]   sr_rd_data
);

   localparam int NRD   = 2;
   localparam int NPORT = NRD + 1;   // read ports first, write port last
   localparam int WP    = NRD;

   if (DATA_W < 1) begin : g_bad_data
      $error("bank_rf: DATA_W must be at least 1");
   end
   if (SR_W < 1) begin : g_bad_sr
      $error("bank_rf: SR_W must be at least 1");
   end
   if (ARCH_N != (1 << ARCH_W)) begin : g_bad_arch
      $error("bank_rf: register numbering must fill the index width");
   end

   logic [NPORT-1:0][ARCH_W-1:0] arch_idx;
   logic [NPORT-1:0][PHYS_W-1:0] phys_idx;
   logic                         has_sr;
   logic [SLOT_W-1:0]            sr_slot;

   assign arch_idx[0]  = rd_a_idx;
   assign arch_idx[1]  = rd_b_idx;
   assign arch_idx[WP] = wr_idx;

   bank_rf_decode #(.NPORT(NPORT)) u_dec (
      .mode_i   (mode_i),
      .arch_idx (arch_idx),
      .phys_idx (phys_idx),
      .has_sr   (has_sr),
      .sr_slot  (sr_slot)
   );

   // general registers
   logic [NRD-1:0][PHYS_W-1:0] gp_ridx;
   logic [NRD-1:0][DATA_W-1:0] gp_rdata;
   logic                       gp_we;

   assign gp_we = wr_en && (int'(wr_idx) != PC_IDX);

   for (genvar p = 0; p < NRD; p++) begin : g_gp_idx
      assign gp_ridx[p] = phys_idx[p];
   end

   bank_rf_store #(
      .DATA_W  (DATA_W),
      .DEPTH   (PHYS_N),
      .NRD     (NRD),
      .RST_VAL (RST_VAL)
   ) u_gp (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (gp_we),
      .widx  (phys_idx[WP]),
      .wdata (wr_data),
      .ridx  (gp_ridx),
      .rdata (gp_rdata)
   );

   logic [NRD-1:0][DATA_W-1:0] rd_mux;
   for (genvar p = 0; p < NRD; p++) begin : g_pc_sel
      always_comb rd_mux[p] = (int'(arch_idx[p]) == PC_IDX) ? pc_i : gp_rdata[p];
   end
   assign rd_a_data = rd_mux[0];
   assign rd_b_data = rd_mux[1];

   // saved status words, one per exception mode
   logic [0:0][SLOT_W-1:0] sr_ridx;
   logic [0:0][SR_W-1:0]   sr_rdata;

   assign sr_ridx[0] = sr_slot;

   bank_rf_store #(
      .DATA_W  (SR_W),
      .DEPTH   (SLOT_N),
      .NRD     (1),
      .RST_VAL ('0)
   ) u_sr (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (sr_wr_en && has_sr),
      .widx  (sr_slot),
      .wdata (sr_wr_data),
      .ridx  (sr_ridx),
      .rdata (sr_rdata)
   );

   assign sr_rd_data = has_sr ? sr_rdata[0] : '0;

endmodule

// File: rtl/bank_rf_chk.sv
module bank_rf_chk #(
   parameter int DATA_W = 32,
   parameter int SR_W   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        mode_i,
   input logic [3:0]        rd_a_idx,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [3:0]        rd_b_idx,
   input logic [DATA_W-1:0] rd_b_data,
   input logic              wr_en,
   input logic [3:0]        wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] pc_i,
   input logic              sr_wr_en,
   input logic [SR_W-1:0]   sr_wr_data,
   input logic [SR_W-1:0]   sr_rd_data
);

   logic exc_mode, unpriv_mode, unknown_mode;
   always_comb begin
      exc_mode     = (mode_i == 5'b10001) || (mode_i == 5'b10010) || (mode_i == 5'b10011) ||
                     (mode_i == 5'b10111) || (mode_i == 5'b11011);
      unpriv_mode  = (mode_i == 5'b10000) || (mode_i == 5'b11111);
      unknown_mode = !exc_mode && !unpriv_mode;
   end

   a_r5_pc_port_a: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == 4'd15) |-> (rd_a_data == pc_i));

   a_r5_pc_port_b: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_b_idx == 4'd15) |-> (rd_b_data == pc_i));

   a_r2_shared_low: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx < 4'd8) |=>
      (rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data)));

   a_r8_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx != 4'd15) |=>
      (mode_i != $past(mode_i) || rd_b_idx != $past(wr_idx) || rd_b_data == $past(wr_data)));

   a_r6_sr_write: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr_en && exc_mode) |=>
      (mode_i != $past(mode_i) || sr_rd_data == $past(sr_wr_data)));

   a_r7_sr_zero_unpriv: assert property (@(posedge clk) disable iff (!rst_n)
      unpriv_mode |-> (sr_rd_data == '0));

   a_r9_sr_zero_unknown: assert property (@(posedge clk) disable iff (!rst_n)
      unknown_mode |-> (sr_rd_data == '0));

endmodule

bind bank_rf bank_rf_chk #(.DATA_W(DATA_W), .SR_W(SR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_i     (mode_i),
   .rd_a_idx   (rd_a_idx),
   .rd_a_data  (rd_a_data),
   .rd_b_idx   (rd_b_idx),
   .rd_b_data  (rd_b_data),
   .wr_en      (wr_en),
   .wr_idx     (wr_idx),
   .wr_data    (wr_data),
   .pc_i       (pc_i),
   .sr_wr_en   (sr_wr_en),
   .sr_wr_data (sr_wr_data),
   .sr_rd_data (sr_rd_data)
);

// File: tb/bank_rf_test.sv
`timescale 1ns/1ps
module bank_rf_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  mode_i = 5'b10000;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, wr_data = '0, pc_i = '0;
   logic        wr_en = 1'b0, sr_wr_en = 1'b0;
   logic [31:0] sr_wr_data = '0, sr_rd_data;

   int n_chk = 0;
   int n_bad = 0;
   string tag_override = "";

   always #5 clk = ~clk;

   bank_rf uut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .pc_i(pc_i),
      .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .sr_rd_data(sr_rd_data)
   );

   // bench model, kept per kind of storage
   logic [31:0] m_low [8];
   logic [31:0] m_usr [7];   // user copies of 8..14
   logic [31:0] m_fiq [7];   // fast-interrupt copies of 8..14
   logic [31:0] m_sp  [4];   // 13 for irq, svc, abt, und
   logic [31:0] m_lr  [4];   // 14 for the same four
   logic [31:0] m_sr  [5];   // fiq, irq, svc, abt, und

   localparam logic [4:0] MODES [9] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                        5'b10111, 5'b11011, 5'b11111, 5'b00000, 5'b10100};

   // 0 user-like, 1 fast, 2 irq, 3 svc, 4 abt, 5 und
   function automatic int kind(input logic [4:0] m);
      if (m == 5'b10001) return 1;
      if (m == 5'b10010) return 2;
      if (m == 5'b10011) return 3;
      if (m == 5'b10111) return 4;
      if (m == 5'b11011) return 5;
      return 0;
   endfunction

   function automatic logic known(input logic [4:0] m);
      return kind(m) != 0 || m == 5'b10000 || m == 5'b11111;
   endfunction

   function automatic logic [31:0] m_read(input logic [4:0] m, input logic [3:0] i, input logic [31:0] pc);
      int k = kind(m);
      if (i == 4'd15) return pc;
      if (i < 4'd8)   return m_low[i];
      if (k == 1)     return m_fiq[i - 8];
      if (k == 0 || i < 4'd13) return m_usr[i - 8];
      if (i == 4'd13) return m_sp[k - 2];
      return m_lr[k - 2];
   endfunction

   function automatic logic [31:0] m_sr_read(input logic [4:0] m);
      int k = kind(m);
      if (k == 0) return '0;
      return m_sr[k - 1];
   endfunction

   task automatic m_write(input logic [4:0] m, input logic [3:0] i, input logic [31:0] d);
      int k = kind(m);
      if (i == 4'd15) return;
      if (i < 4'd8) m_low[i] = d;
      else if (k == 1) m_fiq[i - 8] = d;
      else if (k == 0 || i < 4'd13) m_usr[i - 8] = d;
      else if (i == 4'd13) m_sp[k - 2] = d;
      else m_lr[k - 2] = d;
   endtask

   task automatic m_clear();
      for (int j = 0; j < 8; j++) m_low[j] = '0;
      for (int j = 0; j < 7; j++) begin m_usr[j] = '0; m_fiq[j] = '0; end
      for (int j = 0; j < 4; j++) begin m_sp[j] = '0; m_lr[j] = '0; end
      for (int j = 0; j < 5; j++) m_sr[j] = '0;
   endtask

   function automatic string reg_tag(input logic [4:0] m, input logic [3:0] ri);
      if (tag_override != "") return tag_override;
      if (wr_en && wr_idx == ri && ri != 4'd15) return "R8";
      if (ri == 4'd15) return "R5";
      if (ri < 4'd8) return "R2";
      if (!known(m)) return "R9";
      if (ri < 4'd13) return "R3";
      return "R4";
   endfunction

   function automatic string sr_tag(input logic [4:0] m);
      if (tag_override != "") return tag_override;
      if (!known(m)) return "R9";
      if (kind(m) == 0) return "R7";
      return "R6";
   endfunction

   task automatic check(input logic ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // one cycle: drive at the falling edge, compare with pre-edge model, then apply the edge to the model
   task automatic step(input logic [4:0] m, input logic [3:0] ra, input logic [3:0] rb,
                       input logic we, input logic [3:0] wi, input logic [31:0] wd,
                       input logic swe, input logic [31:0] swd, input logic [31:0] pc);
      logic [31:0] ea, eb, es;
      @(negedge clk);
      mode_i = m; rd_a_idx = ra; rd_b_idx = rb;
      wr_en = we; wr_idx = wi; wr_data = wd;
      sr_wr_en = swe; sr_wr_data = swd; pc_i = pc;
      #1;
      ea = m_read(m, ra, pc);
      eb = m_read(m, rb, pc);
      es = m_sr_read(m);
      check(rd_a_data === ea, reg_tag(m, ra), "port A", rd_a_data, ea);
      check(rd_b_data === eb, reg_tag(m, rb), "port B", rd_b_data, eb);
      check(sr_rd_data === es, sr_tag(m), "status", sr_rd_data, es);
      if (we) m_write(m, wi, wd);
      if (swe && kind(m) != 0) m_sr[kind(m) - 1] = swd;
   endtask

   task automatic sweep(input string tag);
      tag_override = tag;
      for (int mi = 0; mi < 9; mi++)
         for (int r = 0; r < 15; r += 2)
            step(MODES[mi], 4'(r), 4'(r + 1), 1'b0, 4'd0, 32'd0, 1'b0, 32'd0, 32'h0000_8000 + 32'(r));
      tag_override = "";
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hDEAD_BEEF;
      sr_wr_en = 1'b1; mode_i = 5'b10011;
      repeat (2) @(negedge clk);
      rst_n = 1'b1; wr_en = 1'b0; sr_wr_en = 1'b0;
      m_clear();
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      m_clear();

      // R10: state after reset in every mode
      do_reset();
      sweep("R10");

      // R4 and R6: distinct stack pointer, link and status per mode
      for (int mi = 0; mi < 7; mi++) begin
         step(MODES[mi], 4'd13, 4'd14, 1'b1, 4'd13, 32'h1300_0000 + 32'(mi), 1'b1, 32'h5500_0000 + 32'(mi), 32'd0);
         step(MODES[mi], 4'd13, 4'd14, 1'b1, 4'd14, 32'h1400_0000 + 32'(mi), 1'b0, 32'd0, 32'd0);
      end
      // R3: user and fast-interrupt copies of 8..12
      for (int r = 8; r < 13; r++) begin
         step(5'b10000, 4'(r), 4'(r), 1'b1, 4'(r), 32'hA000_0000 + 32'(r), 1'b0, 32'd0, 32'd0);
         step(5'b10001, 4'(r), 4'(r), 1'b1, 4'(r), 32'hF000_0000 + 32'(r), 1'b0, 32'd0, 32'd0);
      end
      // R2: shared low registers
      for (int r = 0; r < 8; r++)
         step(MODES[r % 7], 4'(r), 4'(r), 1'b1, 4'(r), 32'h0100_0000 * 32'(r + 1), 1'b0, 32'd0, 32'd0);
      sweep("R1");

      // R9: unknown encodings reach the user bank, status write dropped
      step(5'b00000, 4'd13, 4'd9, 1'b1, 4'd13, 32'h0BAD_0013, 1'b1, 32'hFFFF_FFFF, 32'd0);
      step(5'b10100, 4'd13, 4'd14, 1'b0, 4'd0, 32'd0, 1'b1, 32'h1234_5678, 32'd0);
      tag_override = "R9";
      step(5'b10000, 4'd13, 4'd9, 1'b0, 4'd0, 32'd0, 1'b0, 32'd0, 32'd0);
      tag_override = "";
      // R7: status write in user/system is dropped; read it back in each exception mode
      step(5'b10000, 4'd0, 4'd1, 1'b0, 4'd0, 32'd0, 1'b1, 32'hEEEE_0000, 32'd0);
      step(5'b11111, 4'd0, 4'd1, 1'b0, 4'd0, 32'd0, 1'b1, 32'hEEEE_1111, 32'd0);
      tag_override = "R7";
      for (int mi = 1; mi < 6; mi++)
         step(MODES[mi], 4'd0, 4'd1, 1'b0, 4'd0, 32'd0, 1'b0, 32'd0, 32'd0);
      tag_override = "";

      // R5: write to register 15 in each mode alters nothing
      for (int mi = 0; mi < 7; mi++)
         step(MODES[mi], 4'd15, 4'd14, 1'b1, 4'd15, 32'h7777_0000 + 32'(mi), 1'b0, 32'd0, 32'hC0DE_0000 + 32'(mi));
      sweep("R5");

      // R8: same-cycle write and read of one register
      step(5'b10011, 4'd3, 4'd13, 1'b1, 4'd3, 32'h3333_3333, 1'b0, 32'd0, 32'd0);
      step(5'b10011, 4'd13, 4'd3, 1'b1, 4'd13, 32'h1313_1313, 1'b1, 32'h6666_6666, 32'd0);
      step(5'b10011, 4'd13, 4'd3, 1'b0, 4'd0, 32'd0, 1'b0, 32'd0, 32'd0);

      // constrained random: few register numbers and modes to force collisions
      for (int n = 0; n < 4000; n++) begin
         logic [4:0]  m;
         logic [3:0]  ra, rb, wi;
         m  = MODES[$urandom_range(0, 8)];
         wi = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(7, 15));
         ra = ($urandom_range(0, 2) == 0) ? wi : 4'($urandom_range(0, 15));
         rb = ($urandom_range(0, 2) == 0) ? wi : 4'($urandom_range(7, 15));
         step(m, ra, rb, 1'($urandom_range(0, 1)), wi, $urandom(),
              ($urandom_range(0, 3) == 0), $urandom(), $urandom());
      end

      // R10: a second reset wipes everything written above
      do_reset();
      sweep("R10");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule